// File: doc/BRIEF.md
# Three-Wire Serial Slave Port

This block is the device side of a three-wire serial link: an enable line, a serial clock and one bidirectional data line. The enable, serial clock and data inputs are brought into the fast system clock domain through a synchroniser, and serial clock edges are detected there. All shifting runs on those detected edges.

A transfer opens with an eight-bit command. The command picks a direction, a register space and a five-bit register address. The port then either collects write bytes or serialises read bytes. On the register-bank side it raises a one-cycle write strobe or read strobe with an address, a space bit and a data byte. The bank answers a read strobe with its data one system clock later. The port also drives the output enable of the data pin's tri-state buffer. Dropping the enable line aborts whatever is in flight.

Top module: `tw_serial_slave`

## Requirements
- R1: After reset, `dioOe`, `wrStb` and `rdStb` are all 0.
- R2: With the enable input low, `dioOe` is 0 within 5 system clocks. A byte that is only partly received when enable falls never produces a `wrStb`.
- R3: The command byte arrives LSB first. Bit 0 = 1 means read and 0 means write. Bits 5..1 hold the address. Bit 6 selects the space, with 0 for clock space and 1 for RAM space and `regSpace` carrying that value. Bit 7 is the write enable.
- R4: Data-line bits are taken on rising serial clock edges. Write data bytes are assembled LSB first.
- R5: On a read, bits are driven on falling serial clock edges, LSB first. The first data bit appears on the first falling edge after the eighth command bit. `dioOe` returns to 0 after every rising serial clock edge.
- R6: A non-burst write issues exactly one `wrStb` after its eighth data bit, carrying the command's address, space and byte. Any further serial clocks before enable falls are ignored.
- R7: A write command whose bit 7 is 0 produces no `wrStb`, and the addressed register keeps its old value.
- R8: While enable stays high, a read keeps sending bytes from consecutive addresses, starting at the command's address.
- R9: Command address 31 selects burst mode. Burst writes and reads start at address 0 and move up by one per byte.
- R10: Each read byte is preceded by exactly one one-cycle `rdStb`. `rdData` is taken on the system clock after that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceIn | input | 1 | Transfer enable, high during a transfer |
| sclkIn | input | 1 | Serial clock |
| dioIn | input | 1 | Data line as seen from the pad |
| dioOut | output | 1 | Data line value to drive |
| dioOe | output | 1 | Output enable for the data line buffer |
| wrStb | output | 1 | One-cycle write strobe to the register bank |
| rdStb | output | 1 | One-cycle read strobe to the register bank |
| regSpace | output | 1 | Space select: 0 clock, 1 RAM |
| regAddr | output | 5 | Register address |
| wrData | output | 8 | Write byte |
| rdData | input | 8 | Read byte from the bank, valid one clock after rdStb |

## Verification
The port is exercised with single writes into both spaces, a write with its enable bit cleared, and a single read that runs on into the next address. It is also exercised with burst writes and reads at address 31, and with transfers aborted mid-byte for both write and read. The write cases check that address, space and data fields are decoded from the right bit positions. The trailing clocks after a write check that extra clocks are ignored. The read run-on and the bursts check the address stepping and its start point. The aborts check that a partial byte is thrown away and that the data pin is released.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef struct packed {
    logic shiftIn;
    logic loadCmd;
    logic incAddr;
    logic loadOut;
    logic shiftOut;
  } twsStrobes_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceIn,
  input  logic sclkIn,
  input  logic dioIn,
  output logic ceS,
  output logic dinS,
  output logic sclkRise,
  output logic sclkFall
);
  localparam int W = 3;
  logic [W-1:0] pipe [STAGES];
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      sclkPrev <= 1'b0;
    end else begin
      pipe[0] <= {ceIn, sclkIn, dioIn};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclkPrev <= pipe[STAGES-1][1];
    end
  end

  assign ceS      = pipe[STAGES-1][2];
  assign dinS     = pipe[STAGES-1][0];
  assign sclkRise = pipe[STAGES-1][1] & ~sclkPrev;
  assign sclkFall = ~pipe[STAGES-1][1] & sclkPrev;
endmodule

// File: rtl/tws_dpath.sv
module tws_dpath
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobes_t       st,
  input  logic              dinS,
  input  logic [DATA_W-1:0] rdData,
  output logic              cmdIsRead,
  output logic              cmdWrEn,
  output logic              cmdBurst,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-4:0] regAddr,
  output logic              regSpace,
  output logic              dioOut
);
  localparam int ADDR_W = DATA_W - 3;

  logic [DATA_W-1:0] inSh, outSh, inByteNext;
  logic [ADDR_W-1:0] curAddr, cmdAddr;
  logic spaceQ, doutQ;

  assign inByteNext = {dinS, inSh[DATA_W-1:1]};
  assign cmdAddr    = inByteNext[ADDR_W:1];
  assign cmdBurst   = &cmdAddr;
  assign cmdIsRead  = inByteNext[0];
  assign cmdWrEn    = inByteNext[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSh    <= '0;
      outSh   <= '0;
      curAddr <= '0;
      spaceQ  <= 1'b0;
      doutQ   <= 1'b0;
    end else begin
      if (st.shiftIn) inSh <= inByteNext;
      if (st.loadCmd) begin
        curAddr <= cmdBurst ? '0 : cmdAddr;
        spaceQ  <= inByteNext[DATA_W-2];
      end else if (st.incAddr) begin
        curAddr <= curAddr + 1'b1;
      end
      if (st.loadOut) begin
        outSh <= rdData;
      end else if (st.shiftOut) begin
        doutQ <= outSh[0];
        outSh <= {1'b0, outSh[DATA_W-1:1]};
      end
    end
  end

  assign wrData   = inSh;
  assign regAddr  = curAddr;
  assign regSpace = spaceQ;
  assign dioOut   = doutQ;

  // R9: a burst command always starts the address at zero
  a_r9_burst_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadCmd && cmdBurst) |=> (curAddr == '0));
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceS,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        cmdIsRead,
  input  logic        cmdWrEn,
  input  logic        cmdBurst,
  output twsStrobes_t st,
  output logic        wrStb,
  output logic        rdStb,
  output logic        dioOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WDATA, S_WSTB, S_RFETCH, S_RWAIT, S_RDATA, S_IGNORE
  } state_t;

  state_t state;
  logic [CNT_W-1:0] bitCnt;
  logic burstQ, oeQ, byteEnd, counting;

  assign counting = (state == S_CMD) || (state == S_WDATA) || (state == S_RDATA);
  assign byteEnd  = sclkRise && counting && (bitCnt == LAST);

  always_comb begin
    st          = '0;
    st.shiftIn  = sclkRise && ((state == S_CMD) || (state == S_WDATA));
    st.loadCmd  = byteEnd && (state == S_CMD);
    st.incAddr  = (state == S_WSTB) || (state == S_RFETCH);
    st.loadOut  = (state == S_RWAIT);
    st.shiftOut = sclkFall && (state == S_RDATA);
  end

  assign wrStb = (state == S_WSTB);
  assign rdStb = (state == S_RFETCH);
  assign dioOe = oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      burstQ <= 1'b0;
      oeQ    <= 1'b0;
    end else if (!ceS) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      oeQ    <= 1'b0;
    end else begin
      if (sclkRise && counting) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      if (st.loadCmd) burstQ <= cmdBurst;
      if (state != S_RDATA || sclkRise) oeQ <= 1'b0;
      else if (sclkFall) oeQ <= 1'b1;
      case (state)
        S_IDLE:   state <= S_CMD;
        S_CMD:    if (byteEnd) state <= cmdIsRead ? S_RFETCH : (cmdWrEn ? S_WDATA : S_IGNORE);
        S_WDATA:  if (byteEnd) state <= S_WSTB;
        S_WSTB:   state <= burstQ ? S_WDATA : S_IGNORE;
        S_RFETCH: state <= S_RWAIT;
        S_RWAIT:  state <= S_RDATA;
        S_RDATA:  if (byteEnd) state <= S_RFETCH;
        default:  state <= S_IGNORE;
      endcase
    end
  end

  // R2: pin released once the enable is seen low
  a_r2_release_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !ceS |=> !dioOe);
  // R2: strobes only follow a cycle with enable high
  a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb || rdStb) |-> $past(ceS));
  // R5: pin released after each rising serial edge
  a_r5_release_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    sclkRise |=> !dioOe);
  // R5: pin only starts driving right after a falling serial edge
  a_r5_drive_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dioOe) |-> $past(sclkFall));
  // R6: write strobe is a single cycle
  a_r6_wr_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);
  // R10: read strobe is a single cycle and never overlaps a write
  a_r10_rd_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> (!rdStb && !wrStb));
endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceIn,
  input  logic              sclkIn,
  input  logic              dioIn,
  output logic              dioOut,
  output logic              dioOe,
  output logic              wrStb,
  output logic              rdStb,
  output logic              regSpace,
  output logic [DATA_W-4:0] regAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdData
);
  twsStrobes_t st;
  logic ceS, dinS, sclkRise, sclkFall;
  logic cmdIsRead, cmdWrEn, cmdBurst;

  tws_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclkIn(sclkIn), .dioIn(dioIn),
    .ceS(ceS), .dinS(dinS), .sclkRise(sclkRise), .sclkFall(sclkFall));

  tws_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceS(ceS), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .cmdIsRead(cmdIsRead), .cmdWrEn(cmdWrEn), .cmdBurst(cmdBurst),
    .st(st), .wrStb(wrStb), .rdStb(rdStb), .dioOe(dioOe));

  tws_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .dinS(dinS), .rdData(rdData),
    .cmdIsRead(cmdIsRead), .cmdWrEn(cmdWrEn), .cmdBurst(cmdBurst),
    .wrData(wrData), .regAddr(regAddr), .regSpace(regSpace), .dioOut(dioOut));
endmodule

// File: tb/tw_serial_slave_tb.sv
module tw_serial_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, ceIn = 1'b0, sclkIn = 1'b0, dioIn = 1'b0;
  logic dioOut, dioOe, wrStb, rdStb, regSpace;
  logic [4:0] regAddr;
  logic [7:0] wrData, rdData;
  logic [7:0] bankMem [64];
  logic [7:0] refMem [64];
  logic [13:0] expQ [$];
  int total = 0, bad = 0, ceLowCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_serial_slave dut_i (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclkIn(sclkIn), .dioIn(dioIn),
    .dioOut(dioOut), .dioOe(dioOe), .wrStb(wrStb), .rdStb(rdStb),
    .regSpace(regSpace), .regAddr(regAddr), .wrData(wrData), .rdData(rdData));

  // behavioural register bank: answers rdStb one clock later (R10)
  always_ff @(posedge clk) begin
    if (wrStb) bankMem[{regSpace, regAddr}] <= wrData;
    if (rdStb) rdData <= bankMem[{regSpace, regAddr}];
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // per-clock comparison against the expected write list and the enable rule
  always @(negedge clk) begin
    if (rstN) begin
      if (wrStb) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R6/R7/R2 actual=unexpected write %0h expected=none",
                   {regSpace, regAddr, wrData});
        end else begin
          logic [13:0] e;
          e = expQ.pop_front();
          if ({regSpace, regAddr, wrData} !== e) begin
            bad++;
            $display("FAIL R3/R4 actual=%0h expected=%0h", {regSpace, regAddr, wrData}, e);
          end
        end
      end
      ceLowCnt = ceIn ? 0 : ceLowCnt + 1;
      if (ceLowCnt >= 5) check("R2 idle release", dioOe, 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferStart();
    @(negedge clk); sclkIn = 0; ceIn = 1; tick(HALF);
  endtask

  task automatic xferEnd();
    @(negedge clk); sclkIn = 0; tick(2); ceIn = 0; dioIn = 0; tick(2*HALF);
  endtask

  task automatic sendBit(logic b);
    @(negedge clk); sclkIn = 0; dioIn = b; tick(HALF);
    sclkIn = 1; tick(HALF);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
  endtask

  task automatic expectWrite(logic sp, logic [4:0] ad, logic [7:0] d);
    expQ.push_back({sp, ad, d});
    refMem[{sp, ad}] = d;
  endtask

  task automatic recvByte(string req, logic [7:0] exp);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclkIn = 0; tick(HALF);
      check("R5 driving after fall", dioOe, 1);
      b[i] = dioOut;
      sclkIn = 1; tick(5);
      check("R5 release after rise", dioOe, 0);
      tick(HALF - 5);
    end
    check(req, b, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 64; i++) begin
      bankMem[i] = 8'(i * 7 + 1);
      refMem[i]  = 8'(i * 7 + 1);
    end
    tick(4);
    check("R1 oe at reset", dioOe, 0);
    check("R1 wrStb at reset", wrStb, 0);
    check("R1 rdStb at reset", rdStb, 0);
    rstN = 1; tick(4);

    // R6 R3 R4: clock space addr 5, then trailing clocks that must be ignored
    xferStart(); expectWrite(0, 5, 8'h3C);
    sendByte(8'h8A); sendByte(8'h3C); sendByte(8'hFF); xferEnd();
    check("R6 write consumed", expQ.size(), 0);

    // R3: RAM space addr 2
    xferStart(); expectWrite(1, 2, 8'hA5);
    sendByte(8'hC4); sendByte(8'hA5); xferEnd();
    check("R3 ram write consumed", expQ.size(), 0);

    // R7: write enable bit cleared, addr 5
    xferStart(); sendByte(8'h0A); sendByte(8'h77); xferEnd();

    // R8 R10 R5: read clock addr 5, run on into addr 6
    xferStart(); sendByte(8'h8B);
    recvByte("R7 R8 first byte", refMem[5]);
    recvByte("R8 run-on byte", refMem[6]);
    xferEnd();

    // R9: burst write into RAM, then burst read back
    xferStart(); sendByte(8'hFE);
    expectWrite(1, 0, 8'h11); expectWrite(1, 1, 8'h22); expectWrite(1, 2, 8'h33);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); xferEnd();
    check("R9 burst writes consumed", expQ.size(), 0);
    xferStart(); sendByte(8'hFF);
    recvByte("R9 burst byte0", 8'h11);
    recvByte("R9 burst byte1", 8'h22);
    recvByte("R9 burst byte2", 8'h33);
    recvByte("R9 burst byte3", refMem[32 + 3]);
    xferEnd();

    // R2: partial write byte dropped
    xferStart(); sendByte(8'h8A);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    xferEnd();
    xferStart(); sendByte(8'h8B);
    recvByte("R2 partial write dropped", 8'h3C);
    xferEnd();

    // R2: enable dropped while driving
    xferStart(); sendByte(8'h8B);
    @(negedge clk); sclkIn = 0; tick(HALF);
    check("R2 driving before abort", dioOe, 1);
    ceIn = 0; tick(5);
    check("R2 released after abort", dioOe, 0);
    tick(2*HALF);

    check("R6 no pending writes", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule